// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor with Target-Less Entries

This block sits beside the fetch program counter and guesses the next fetch address. It holds a small fully associative set of entries, each tagged with the full address of a branch or jump. Every cycle the fetch address is compared against every stored tag at once. An entry can be in one of three states. It can be unknown, so the block makes no guess. It can be known and carry a target, so the block redirects fetch there. It can be known but carry a zero target, meaning "taken, destination not known". In that last case the next-PC output stays sequential and a separate flag tells the fetch logic that the control transfer is expected to be taken.

Training arrives on a resolution port once a conditional branch or an unconditional jump has resolved. Results from killed instructions are discarded. A resolved address that is already stored updates its entry in place. A new address claims a slot chosen by a rotating pointer. Lookup results are registered, so a guess for the address presented in one cycle appears after the next clock edge.

Top module: `tgtless_btb`

## Requirements
- R1: While `rst` is high, every clock edge empties all entries, sets the replacement pointer to slot 0 and clears `pred_npc`, `pred_redir` and `pred_unk` to zero.
- R2: If `fetch_pc` matches no stored tag, or matches an entry whose valid bit is 0, then one edge later `pred_npc` = `fetch_pc`+4 and both `pred_redir` and `pred_unk` are 0.
- R3: If `fetch_pc` matches a valid entry with a nonzero target, then one edge later `pred_npc` equals that target, `pred_redir` = 1 and `pred_unk` = 0.
- R4: If `fetch_pc` matches a valid entry whose target is all zeros, then one edge later `pred_npc` = `fetch_pc`+4, `pred_unk` = 1 and `pred_redir` = 0.
- R5: A lookup uses the table contents from before the clock edge that records its result. A resolution accepted at that same edge does not affect it.
- R6: A resolution with `res_kill` = 1, or with `res_vld` = 0, leaves the table and the pointer unchanged.
- R7: An accepted resolution whose `res_pc` is already stored overwrites that entry in place. The valid bit becomes `res_taken` and the target becomes `res_tgt`. No other slot changes.
- R8: An accepted resolution whose `res_pc` is not stored is written to the slot the pointer selects, with valid = `res_taken`. The pointer then advances through slots 0,1,2,3 and wraps to 0, evicting the oldest allocation.
- R9: `pred_redir` and `pred_unk` are never 1 in the same cycle, and no two entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Fetch address to look up |
| res_vld | input | 1 | Resolution record present |
| res_kill | input | 1 | Resolved instruction was squashed; ignore record |
| res_pc | input | PC_W | Address of the resolved branch or jump |
| res_taken | input | 1 | Resolved outcome, written as the valid bit |
| res_tgt | input | PC_W | Resolved target; all zeros stores "target unknown" |
| pred_npc | output | PC_W | Predicted next fetch address (registered) |
| pred_redir | output | 1 | Prediction supplies a target (registered) |
| pred_unk | output | 1 | Taken predicted, target not known (registered) |

## Verification
The assertions assume reset is held for at least one edge before use. They also assume that `res_pc`, `res_taken` and `res_tgt` matter only when `res_vld` is high. The stimulus meets both conditions: it starts under reset, then drives resolution fields on every cycle, with random values even while `res_vld` is low. Fetch and resolution addresses are drawn from a small pool. This makes tag hits, in-place updates, same-cycle update and lookup of one address, and evictions frequent. Targets include zero often, so the target-less state is exercised.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    PK_NONE    = 2'd0,
    PK_TARGET  = 2'd1,
    PK_UNKNOWN = 2'd2
  } pkind_t;
endpackage

// File: rtl/btb_cam.sv
module btb_cam #(
  parameter int PC_W  = 32,
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0]           used,
  input  logic [N_ENT-1:0][PC_W-1:0] tags,
  input  logic [PC_W-1:0]            key,
  output logic [N_ENT-1:0]           hit
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit[g] = used[g] && (tags[g] == key);
  end
endmodule

// File: rtl/btb_rr.sv
module btb_rr #(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      if (ptr == IDX_W'(N_ENT - 1)) ptr <= '0;
      else                          ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tgtless_btb.sv
module tgtless_btb #(
  parameter int PC_W  = 32,
  parameter int N_ENT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            res_vld,
  input  logic            res_kill,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_tgt,
  output logic [PC_W-1:0] pred_npc,
  output logic            pred_redir,
  output logic            pred_unk
);
  import btb_pkg::*;
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0][PC_W-1:0] tag_q;
  logic [N_ENT-1:0][PC_W-1:0] tgt_q;
  logic [N_ENT-1:0]           used_q;
  logic [N_ENT-1:0]           vld_q;

  logic [N_ENT-1:0] lk_hit;
  logic [N_ENT-1:0] up_hit;
  logic [IDX_W-1:0] ptr_q;

  btb_cam #(.PC_W(PC_W), .N_ENT(N_ENT)) u_lk_cam (
    .used(used_q), .tags(tag_q), .key(fetch_pc), .hit(lk_hit)
  );
  btb_cam #(.PC_W(PC_W), .N_ENT(N_ENT)) u_up_cam (
    .used(used_q), .tags(tag_q), .key(res_pc), .hit(up_hit)
  );

  // lookup select
  logic            lk_vld;
  logic [PC_W-1:0] lk_tgt;
  pkind_t          lk_kind;
  always_comb begin
    lk_vld = 1'b0;
    lk_tgt = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (lk_hit[i]) begin
        lk_vld = vld_q[i];
        lk_tgt = tgt_q[i];
      end
    end
    if (!lk_vld)            lk_kind = PK_NONE;
    else if (lk_tgt == '0)  lk_kind = PK_UNKNOWN;
    else                    lk_kind = PK_TARGET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_npc   <= '0;
      pred_redir <= 1'b0;
      pred_unk   <= 1'b0;
    end else begin
      pred_npc   <= (lk_kind == PK_TARGET) ? lk_tgt : fetch_pc + PC_W'(4);
      pred_redir <= (lk_kind == PK_TARGET);
      pred_unk   <= (lk_kind == PK_UNKNOWN);
    end
  end

  // training
  logic             res_go;
  logic             up_any;
  logic             alloc_fire;
  logic [IDX_W-1:0] up_idx;
  logic [IDX_W-1:0] wr_idx;
  always_comb begin
    up_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (up_hit[i]) up_idx = IDX_W'(i);
    end
  end
  assign res_go     = res_vld && !res_kill;
  assign up_any     = |up_hit;
  assign alloc_fire = res_go && !up_any;
  assign wr_idx     = up_any ? up_idx : ptr_q;

  btb_rr #(.N_ENT(N_ENT)) u_rr (
    .clk(clk), .rst(rst), .adv(alloc_fire), .ptr(ptr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      vld_q  <= '0;
    end else if (res_go) begin
      used_q[wr_idx] <= 1'b1;
      vld_q[wr_idx]  <= res_taken;
    end
  end

  // payload storage without reset
  always_ff @(posedge clk) begin
    if (res_go) begin
      tag_q[wr_idx] <= res_pc;
      tgt_q[wr_idx] <= res_tgt;
    end
  end
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int PC_W  = 32,
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             res_vld,
  input logic             res_kill,
  input logic [PC_W-1:0]  pred_npc,
  input logic             pred_redir,
  input logic             pred_unk,
  input logic [N_ENT-1:0] lk_hit,
  input logic [N_ENT-1:0] up_hit,
  input logic             alloc_fire,
  input logic [IDX_W-1:0] ptr_q
);
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pred_redir && pred_unk));

  a_r9_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit) && $onehot0(up_hit));

  a_r3_redirect_nonzero: assert property (@(posedge clk) disable iff (rst)
    pred_redir |-> (pred_npc != '0));

  a_r2_sequential_npc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !pred_redir) |-> (pred_npc == $past(fetch_pc) + PC_W'(4)));

  a_r6_killed_no_alloc: assert property (@(posedge clk) disable iff (rst)
    (res_kill || !res_vld) |-> !alloc_fire);

  a_r8_ptr_moves_on_alloc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(alloc_fire)) |-> $stable(ptr_q));

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pred_npc == '0 && !pred_redir && !pred_unk));
endmodule

bind tgtless_btb btb_chk #(.PC_W(PC_W), .N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .res_vld(res_vld),
  .res_kill(res_kill), .pred_npc(pred_npc), .pred_redir(pred_redir),
  .pred_unk(pred_unk), .lk_hit(lk_hit), .up_hit(up_hit),
  .alloc_fire(alloc_fire), .ptr_q(ptr_q)
);

// File: tb/tgtless_btb_test.sv
module tgtless_btb_test;
  localparam int PC_W = 32;
  localparam int NE   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            res_vld = 1'b0, res_kill = 1'b0, res_taken = 1'b0;
  logic [PC_W-1:0] res_pc = '0, res_tgt = '0;
  logic [PC_W-1:0] pred_npc;
  logic            pred_redir, pred_unk;

  always #10 clk = ~clk;

  tgtless_btb #(.PC_W(PC_W), .N_ENT(NE)) uut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .res_vld(res_vld),
    .res_kill(res_kill), .res_pc(res_pc), .res_taken(res_taken),
    .res_tgt(res_tgt), .pred_npc(pred_npc), .pred_redir(pred_redir),
    .pred_unk(pred_unk)
  );

  int checks = 0, bad = 0;
  bit done = 0;

  // behavioural table
  bit              m_used [NE];
  bit              m_val  [NE];
  logic [PC_W-1:0] m_tag  [NE];
  logic [PC_W-1:0] m_tgt  [NE];
  int              m_ptr;
  logic [PC_W-1:0] e_npc;
  bit              e_redir, e_unk;
  string           e_tag, s_tag;

  task automatic check_out();
    checks++;
    if (pred_npc !== e_npc || pred_redir !== e_redir || pred_unk !== e_unk) begin
      bad++;
      $display("FAIL %s (%s): npc=%h redir=%b unk=%b expected npc=%h redir=%b unk=%b",
               e_tag, s_tag, pred_npc, pred_redir, pred_unk, e_npc, e_redir, e_unk);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] pc, input bit v, input bit k,
                      input logic [PC_W-1:0] rpc, input bit tk,
                      input logic [PC_W-1:0] tg, input string tag);
    int hit;
    @(negedge clk);
    check_out();
    fetch_pc = pc; res_vld = v; res_kill = k; res_pc = rpc;
    res_taken = tk; res_tgt = tg; s_tag = tag;
    // expected lookup from current table (R5: pre-update contents)
    hit = -1;
    for (int i = 0; i < NE; i++) if (m_used[i] && m_tag[i] == pc) hit = i;
    if (hit >= 0 && m_val[hit] && m_tgt[hit] != 0) begin
      e_npc = m_tgt[hit]; e_redir = 1; e_unk = 0; e_tag = "R3";
    end else if (hit >= 0 && m_val[hit]) begin
      e_npc = pc + 4; e_redir = 0; e_unk = 1; e_tag = "R4";
    end else begin
      e_npc = pc + 4; e_redir = 0; e_unk = 0; e_tag = "R2";
    end
    // apply training (R6 killed ignored, R7 in place, R8 round robin)
    if (v && !k) begin
      hit = -1;
      for (int i = 0; i < NE; i++) if (m_used[i] && m_tag[i] == rpc) hit = i;
      if (hit < 0) begin
        hit = m_ptr;
        m_ptr = (m_ptr + 1) % NE;
      end
      m_used[hit] = 1; m_val[hit] = tk; m_tag[hit] = rpc; m_tgt[hit] = tg;
    end
  endtask

  function automatic logic [PC_W-1:0] pick_pc(int r);
    case (r % 6)
      0: return 32'h100; 1: return 32'h104; 2: return 32'h200;
      3: return 32'h204; 4: return 32'h300; default: return 32'h308;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] pick_tgt(int r);
    case (r % 4)
      0: return 32'h0; 1: return 32'h4000; 2: return 32'h2004;
      default: return 32'h888;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_used[i] = 0; m_val[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    e_npc = '0; e_redir = 0; e_unk = 0; e_tag = "R1"; s_tag = "reset";
    check_out();
    rst = 1'b0;
    fetch_pc = 32'h0;
    e_npc = 32'h4; e_redir = 0; e_unk = 0; e_tag = "R1"; s_tag = "first lookup";

    step(32'h100, 0, 0, 32'h0,   0, 32'h0,    "R2 empty table");
    step(32'h100, 1, 1, 32'h100, 1, 32'h4000, "R6 killed update");
    step(32'h100, 0, 0, 32'h0,   0, 32'h0,    "R6 after killed");
    step(32'h100, 1, 0, 32'h100, 1, 32'h4000, "R5 same edge");
    step(32'h100, 0, 0, 32'h0,   0, 32'h0,    "R3 target");
    step(32'h200, 1, 0, 32'h200, 1, 32'h0,    "R4 install empty");
    step(32'h200, 0, 0, 32'h0,   0, 32'h0,    "R4 unknown");
    step(32'h100, 1, 0, 32'h100, 0, 32'h4000, "R7 clear valid");
    step(32'h100, 1, 0, 32'h100, 1, 32'h2004, "R7 new target");
    step(32'h100, 1, 0, 32'h300, 1, 32'h888,  "R8 slot2");
    step(32'h300, 1, 0, 32'h400, 1, 32'h888,  "R8 slot3");
    step(32'h400, 1, 0, 32'h500, 1, 32'h4000, "R8 evict slot0");
    step(32'h100, 0, 0, 32'h0,   0, 32'h0,    "R8 evicted");
    step(32'h200, 0, 0, 32'h0,   0, 32'h0,    "R8 survivor");
    step(32'h500, 1, 1, 32'h600, 1, 32'h4000, "R6 killed no alloc");
    step(32'h600, 0, 0, 32'h0,   0, 32'h0,    "R6 still absent");

    for (int n = 0; n < 4000; n++) begin
      int a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      step(pick_pc(a), (b % 3) != 0, (b % 7) == 0, pick_pc(a >> 5),
           c[0], pick_tgt(c >> 3), "R9 mixed");
    end
    step(32'h0, 0, 0, 32'h0, 0, 32'h0, "R2 drain");
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule